// File: doc/BRIEF.md
# Banked UART Control Register File

This block is the register bank that sits between a host and the core of a 16550-style UART with enhanced functions. The host presents a 4-bit register address with separate read and write strobes on a plain parallel bus. The bank turns these accesses into configuration words, FIFO and reset pulses, and push or pop strobes for the UART core. It returns status words, received data and FIFO fill levels to the host on the same bus.

A single address can reach different registers. The current line-control value chooses one of three banks: general, divisor and enhanced. Inside the general bank, a fourth overlay swaps two addresses when two enable bits are both set. Some configuration bits are locked unless the enhanced-functions bit is set.

Each bus access takes one cycle. Read data is combinational from the address, and there is no wait state or back-pressure, so the host may issue an access on every clock.

Top module: `uart_regbank`

## Requirements
- R1: Bank selection follows the line register. The general bank is active while line bit 7 is 0. The divisor bank is active while bit 7 is 1 and the line value is not 0xBF. The enhanced bank is active while the line value equals 0xBF. Address 0x3 reaches the line register in all three banks.
- R2: The general bank decodes 0x0 (receive data on read, transmit data on write), 0x1 interrupt enable, 0x2 (interrupt status input on read, FIFO control on write), 0x4 modem control, 0x5 line status input, 0x6 modem status input, 0x7 scratch, 0x8 transmit level input, 0x9 receive level input, 0xE soft-reset control and 0xF extra-feature control. Status and level inputs are read as given.
- R3: When modem bit 2 and enhanced bit 4 are both 1, general addresses 0x6 and 0x7 reach the transmission-control and trigger-level registers instead of modem status and scratch.
- R4: While enhanced bit 4 is 0, writes leave the following bits unchanged: interrupt-enable bits 7:4, FIFO-control bits 5:4, modem bits 7:5 and modem bit 2. The other bits of those registers still take the write.
- R5: A write to FIFO control pulses rx_fifo_clr when data bit 1 is set and tx_fifo_clr when data bit 2 is set. Each pulse lasts one cycle, in the cycle after the write. FIFO-control bits 2:1 are not stored and read 0 on cfg_fifo_ctl.
- R6: A receive FIFO clear blocks rhr_pop for reads in the HOLD_CYC (default 2) cycles that follow the write. A transmit FIFO clear blocks thr_push in the same way for writes.
- R7: rhr_pop and thr_push are driven in the same cycle as a read or write of address 0x0, and only while the general bank is active. thr_data carries the bus write data.
- R8: A write with bit 3 set at general address 0xE pulses core_sw_rst in the next cycle. From that cycle on, every writable register holds 0, including the line register.
- R9: Unmapped addresses read 0x00 and ignore writes. Address 0xE reads 0x00. Reserved bits read 0: modem bits 3 and 0, extra-feature bits 6 and 3, and FIFO bit 3.
- R10: In the divisor bank, address 0x0 is the low byte and 0x1 the high byte of cfg_divisor. In the enhanced bank, address 0x2 is the enhanced register and 0x4 to 0x7 are the two XON and two XOFF characters. Every one of these reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| rx_data | input | 8 | Head of receive FIFO |
| st_line | input | 8 | Line status word |
| st_modem | input | 8 | Modem status word |
| st_intr | input | 8 | Interrupt identification word |
| lvl_tx | input | 8 | Transmit FIFO fill level |
| lvl_rx | input | 8 | Receive FIFO fill level |
| thr_push | output | 1 | Push thr_data into transmit FIFO |
| thr_data | output | 8 | Data to push |
| rhr_pop | output | 1 | Pop receive FIFO |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO clear |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO clear |
| core_sw_rst | output | 1 | One-cycle soft reset to core |
| cfg_int_en | output | 8 | Interrupt enable word |
| cfg_fifo_ctl | output | 8 | Stored FIFO control (triggers, enable) |
| cfg_line | output | 8 | Line control word |
| cfg_modem | output | 8 | Modem control word |
| cfg_divisor | output | 16 | Baud divisor |
| cfg_enh | output | 8 | Enhanced feature word |
| cfg_xon_a | output | 8 | First XON character |
| cfg_xon_b | output | 8 | Second XON character |
| cfg_xoff_a | output | 8 | First XOFF character |
| cfg_xoff_b | output | 8 | Second XOFF character |
| cfg_tx_ctl | output | 8 | Transmission control word |
| cfg_trig | output | 8 | Trigger level word |
| cfg_extra | output | 8 | Extra feature word |

## Verification
Read data, rhr_pop and thr_push are combinational, so the bench samples them in the same cycle as the strobe, a few nanoseconds after inputs change on the falling edge. Register contents, FIFO-clear pulses and core_sw_rst appear one clock after the write edge, and the bench checks them just after that rising edge. The hold-off window is counted from the write edge: the two accesses issued in the next two cycles must be blocked and the third must pass. The bench checks all three.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

  localparam int RB_DW = 8;
  localparam int RB_AW = 4;

  localparam logic [RB_DW-1:0] ENH_KEY    = 8'hBF;
  localparam logic [RB_DW-1:0] INTEN_PROT = 8'hF0;
  localparam logic [RB_DW-1:0] FIFO_PROT  = 8'h30;
  localparam logic [RB_DW-1:0] FIFO_KEEP  = 8'hF1;
  localparam logic [RB_DW-1:0] MODEM_PROT = 8'hE4;
  localparam logic [RB_DW-1:0] MODEM_KEEP = 8'hF6;
  localparam logic [RB_DW-1:0] EXTRA_KEEP = 8'hB7;
  localparam logic [RB_DW-1:0] ALL_KEEP   = 8'hFF;
  localparam logic [RB_DW-1:0] NO_PROT    = 8'h00;

  localparam int RX_CLR_BIT  = 1;
  localparam int TX_CLR_BIT  = 2;
  localparam int SRST_BIT    = 3;
  localparam int ENH_GATE    = 4;
  localparam int OVERLAY_BIT = 2;

  typedef enum logic [4:0] {
    S_NONE, S_HOLD, S_INTEN, S_FIFO, S_LINE, S_MODEM, S_LSTAT, S_MSTAT,
    S_SCRATCH, S_TXCTL, S_TRIG, S_TXLVL, S_RXLVL, S_SRST, S_EXTRA,
    S_DIVLO, S_DIVHI, S_ENH, S_XONA, S_XONB, S_XOFFA, S_XOFFB
  } rb_sel_e;

  typedef struct packed {
    logic [RB_DW-1:0] inten;
    logic [RB_DW-1:0] fifo;
    logic [RB_DW-1:0] line;
    logic [RB_DW-1:0] modem;
    logic [RB_DW-1:0] scratch;
    logic [RB_DW-1:0] txctl;
    logic [RB_DW-1:0] trig;
    logic [RB_DW-1:0] extra;
    logic [RB_DW-1:0] divlo;
    logic [RB_DW-1:0] divhi;
    logic [RB_DW-1:0] enh;
    logic [RB_DW-1:0] xona;
    logic [RB_DW-1:0] xonb;
    logic [RB_DW-1:0] xoffa;
    logic [RB_DW-1:0] xoffb;
  } rb_cfg_t;

  // Merge a write with the old value: locked bits keep the old value
  // unless allow is set; bits outside keep read as zero.
  function automatic logic [RB_DW-1:0] guarded_write(
    input logic [RB_DW-1:0] old_v,
    input logic [RB_DW-1:0] new_v,
    input logic [RB_DW-1:0] prot,
    input logic [RB_DW-1:0] keep,
    input logic             allow
  );
    logic [RB_DW-1:0] merged;
    merged = allow ? new_v : ((new_v & ~prot) | (old_v & prot));
    return merged & keep;
  endfunction

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
#(
  parameter int AW = RB_AW,
  parameter int DW = RB_DW
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] line,
  input  logic          overlay_on,
  output rb_sel_e       sel
);

  logic enh_bank;
  logic div_bank;

  assign enh_bank = (line == ENH_KEY);
  assign div_bank = line[DW-1] && !enh_bank;

  always_comb begin
    sel = S_NONE;
    if (enh_bank) begin
      case (addr)
        4'h2:    sel = S_ENH;
        4'h3:    sel = S_LINE;
        4'h4:    sel = S_XONA;
        4'h5:    sel = S_XONB;
        4'h6:    sel = S_XOFFA;
        4'h7:    sel = S_XOFFB;
        default: sel = S_NONE;
      endcase
    end else if (div_bank) begin
      case (addr)
        4'h0:    sel = S_DIVLO;
        4'h1:    sel = S_DIVHI;
        4'h3:    sel = S_LINE;
        default: sel = S_NONE;
      endcase
    end else begin
      case (addr)
        4'h0:    sel = S_HOLD;
        4'h1:    sel = S_INTEN;
        4'h2:    sel = S_FIFO;
        4'h3:    sel = S_LINE;
        4'h4:    sel = S_MODEM;
        4'h5:    sel = S_LSTAT;
        4'h6:    sel = overlay_on ? S_TXCTL : S_MSTAT;
        4'h7:    sel = overlay_on ? S_TRIG : S_SCRATCH;
        4'h8:    sel = S_TXLVL;
        4'h9:    sel = S_RXLVL;
        4'hE:    sel = S_SRST;
        4'hF:    sel = S_EXTRA;
        default: sel = S_NONE;
      endcase
    end
  end

endmodule

// File: rtl/uart_rb_regs.sv
module uart_rb_regs
  import uart_rb_pkg::*;
#(
  parameter int DW = RB_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rb_sel_e       sel,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output rb_cfg_t       cfg,
  output logic          sw_pulse
);

  rb_cfg_t cfg_q;
  logic    allow;
  logic    sw_now;

  assign allow  = cfg_q.enh[ENH_GATE];
  assign sw_now = wr && (sel == S_SRST) && wdata[SRST_BIT];
  assign cfg    = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      sw_pulse <= 1'b0;
    end else begin
      sw_pulse <= sw_now;
      if (sw_now) begin
        cfg_q <= '0;
      end else if (wr) begin
        case (sel)
          S_INTEN:   cfg_q.inten   <= guarded_write(cfg_q.inten, wdata, INTEN_PROT, ALL_KEEP, allow);
          S_FIFO:    cfg_q.fifo    <= guarded_write(cfg_q.fifo, wdata, FIFO_PROT, FIFO_KEEP, allow);
          S_LINE:    cfg_q.line    <= wdata;
          S_MODEM:   cfg_q.modem   <= guarded_write(cfg_q.modem, wdata, MODEM_PROT, MODEM_KEEP, allow);
          S_SCRATCH: cfg_q.scratch <= wdata;
          S_TXCTL:   cfg_q.txctl   <= wdata;
          S_TRIG:    cfg_q.trig    <= wdata;
          S_EXTRA:   cfg_q.extra   <= guarded_write(cfg_q.extra, wdata, NO_PROT, EXTRA_KEEP, allow);
          S_DIVLO:   cfg_q.divlo   <= wdata;
          S_DIVHI:   cfg_q.divhi   <= wdata;
          S_ENH:     cfg_q.enh     <= wdata;
          S_XONA:    cfg_q.xona    <= wdata;
          S_XONB:    cfg_q.xonb    <= wdata;
          S_XOFFA:   cfg_q.xoffa   <= wdata;
          S_XOFFB:   cfg_q.xoffb   <= wdata;
          default:   ;
        endcase
      end
    end
  end

  // R4
  property locked_bits_p;
    @(posedge clk) disable iff (!rst_n)
      (!cfg_q.enh[ENH_GATE] && !sw_now) |=>
        ($stable(cfg_q.inten[7:4]) && $stable(cfg_q.modem[7:5]) &&
         $stable(cfg_q.modem[2]) && $stable(cfg_q.fifo[5:4]));
  endproperty
  locked_bits_chk: assert property (locked_bits_p);

  // R8
  property soft_reset_p;
    @(posedge clk) disable iff (!rst_n)
      sw_now |=> (sw_pulse && cfg_q == '0);
  endproperty
  soft_reset_chk: assert property (soft_reset_p);

endmodule

// File: rtl/uart_rb_holdoff.sv
module uart_rb_holdoff #(
  parameter int HOLD_CYC = 2,
  localparam int CW = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse,
  output logic busy
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= trig;
      if (trig)
        cnt <= CW'(HOLD_CYC);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);

  // R5
  property clr_follows_p;
    @(posedge clk) disable iff (!rst_n) trig |=> pulse;
  endproperty
  clr_follows_chk: assert property (clr_follows_p);

  // R6
  property window_open_p;
    @(posedge clk) disable iff (!rst_n) trig |=> busy;
  endproperty
  window_open_chk: assert property (window_open_p);

endmodule

// File: rtl/uart_rb_rdmux.sv
module uart_rb_rdmux
  import uart_rb_pkg::*;
#(
  parameter int DW = RB_DW
) (
  input  rb_sel_e       sel,
  input  rb_cfg_t       cfg,
  input  logic [DW-1:0] rx_data,
  input  logic [DW-1:0] st_line,
  input  logic [DW-1:0] st_modem,
  input  logic [DW-1:0] st_intr,
  input  logic [DW-1:0] lvl_tx,
  input  logic [DW-1:0] lvl_rx,
  output logic [DW-1:0] rdata
);

  always_comb begin
    case (sel)
      S_HOLD:    rdata = rx_data;
      S_INTEN:   rdata = cfg.inten;
      S_FIFO:    rdata = st_intr;
      S_LINE:    rdata = cfg.line;
      S_MODEM:   rdata = cfg.modem;
      S_LSTAT:   rdata = st_line;
      S_MSTAT:   rdata = st_modem;
      S_SCRATCH: rdata = cfg.scratch;
      S_TXCTL:   rdata = cfg.txctl;
      S_TRIG:    rdata = cfg.trig;
      S_TXLVL:   rdata = lvl_tx;
      S_RXLVL:   rdata = lvl_rx;
      S_EXTRA:   rdata = cfg.extra;
      S_DIVLO:   rdata = cfg.divlo;
      S_DIVHI:   rdata = cfg.divhi;
      S_ENH:     rdata = cfg.enh;
      S_XONA:    rdata = cfg.xona;
      S_XONB:    rdata = cfg.xonb;
      S_XOFFA:   rdata = cfg.xoffa;
      S_XOFFB:   rdata = cfg.xoffb;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RB_AW-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [RB_DW-1:0] bus_wdata,
  output logic [RB_DW-1:0] bus_rdata,
  input  logic [RB_DW-1:0] rx_data,
  input  logic [RB_DW-1:0] st_line,
  input  logic [RB_DW-1:0] st_modem,
  input  logic [RB_DW-1:0] st_intr,
  input  logic [RB_DW-1:0] lvl_tx,
  input  logic [RB_DW-1:0] lvl_rx,
  output logic             thr_push,
  output logic [RB_DW-1:0] thr_data,
  output logic             rhr_pop,
  output logic             rx_fifo_clr,
  output logic             tx_fifo_clr,
  output logic             core_sw_rst,
  output logic [RB_DW-1:0] cfg_int_en,
  output logic [RB_DW-1:0] cfg_fifo_ctl,
  output logic [RB_DW-1:0] cfg_line,
  output logic [RB_DW-1:0] cfg_modem,
  output logic [2*RB_DW-1:0] cfg_divisor,
  output logic [RB_DW-1:0] cfg_enh,
  output logic [RB_DW-1:0] cfg_xon_a,
  output logic [RB_DW-1:0] cfg_xon_b,
  output logic [RB_DW-1:0] cfg_xoff_a,
  output logic [RB_DW-1:0] cfg_xoff_b,
  output logic [RB_DW-1:0] cfg_tx_ctl,
  output logic [RB_DW-1:0] cfg_trig,
  output logic [RB_DW-1:0] cfg_extra
);

  localparam int NCH = 2; // channel 0 receive, channel 1 transmit

  rb_sel_e        sel;
  rb_cfg_t        cfg;
  logic           overlay_on;
  logic           fifo_we;
  logic [NCH-1:0] clr_trig;
  logic [NCH-1:0] clr_pulse;
  logic [NCH-1:0] hold_busy;

  assign overlay_on = cfg.modem[OVERLAY_BIT] && cfg.enh[ENH_GATE];

  uart_rb_decode #(.AW(RB_AW), .DW(RB_DW)) u_dec (
    .addr       (bus_addr),
    .line       (cfg.line),
    .overlay_on (overlay_on),
    .sel        (sel)
  );

  uart_rb_regs #(.DW(RB_DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .cfg      (cfg),
    .sw_pulse (core_sw_rst)
  );

  assign fifo_we     = bus_wr && (sel == S_FIFO);
  assign clr_trig[0] = fifo_we && bus_wdata[RX_CLR_BIT];
  assign clr_trig[1] = fifo_we && bus_wdata[TX_CLR_BIT];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_hold
    uart_rb_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (clr_trig[ch]),
      .pulse (clr_pulse[ch]),
      .busy  (hold_busy[ch])
    );
  end

  assign rx_fifo_clr = clr_pulse[0];
  assign tx_fifo_clr = clr_pulse[1];
  assign rhr_pop     = bus_rd && (sel == S_HOLD) && !hold_busy[0];
  assign thr_push    = bus_wr && (sel == S_HOLD) && !hold_busy[1];
  assign thr_data    = bus_wdata;

  uart_rb_rdmux #(.DW(RB_DW)) u_rd (
    .sel      (sel),
    .cfg      (cfg),
    .rx_data  (rx_data),
    .st_line  (st_line),
    .st_modem (st_modem),
    .st_intr  (st_intr),
    .lvl_tx   (lvl_tx),
    .lvl_rx   (lvl_rx),
    .rdata    (bus_rdata)
  );

  assign cfg_int_en   = cfg.inten;
  assign cfg_fifo_ctl = cfg.fifo;
  assign cfg_line     = cfg.line;
  assign cfg_modem    = cfg.modem;
  assign cfg_divisor  = {cfg.divhi, cfg.divlo};
  assign cfg_enh      = cfg.enh;
  assign cfg_xon_a    = cfg.xona;
  assign cfg_xon_b    = cfg.xonb;
  assign cfg_xoff_a   = cfg.xoffa;
  assign cfg_xoff_b   = cfg.xoffb;
  assign cfg_tx_ctl   = cfg.txctl;
  assign cfg_trig     = cfg.trig;
  assign cfg_extra    = cfg.extra;

  // R7
  property push_general_p;
    @(posedge clk) disable iff (!rst_n) thr_push |-> !cfg_line[RB_DW-1];
  endproperty
  push_general_chk: assert property (push_general_p);

  // R6
  property no_pop_on_clr_p;
    @(posedge clk) disable iff (!rst_n) rx_fifo_clr |-> !rhr_pop;
  endproperty
  no_pop_on_clr_chk: assert property (no_pop_on_clr_p);

  // R6
  property no_push_on_clr_p;
    @(posedge clk) disable iff (!rst_n) tx_fifo_clr |-> !thr_push;
  endproperty
  no_push_on_clr_chk: assert property (no_push_on_clr_p);

endmodule

// File: tb/sim_uart_regbank.sv
`timescale 1ns/1ps
module sim_uart_regbank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  rx_data = 8'hC3;
  logic [7:0]  st_line = 8'h61;
  logic [7:0]  st_modem = 8'h10;
  logic [7:0]  st_intr = 8'hC1;
  logic [7:0]  lvl_tx = 8'h40;
  logic [7:0]  lvl_rx = 8'h05;
  logic        thr_push, rhr_pop, rx_fifo_clr, tx_fifo_clr, core_sw_rst;
  logic [7:0]  thr_data;
  logic [7:0]  cfg_int_en, cfg_fifo_ctl, cfg_line, cfg_modem, cfg_enh;
  logic [15:0] cfg_divisor;
  logic [7:0]  cfg_xon_a, cfg_xon_b, cfg_xoff_a, cfg_xoff_b;
  logic [7:0]  cfg_tx_ctl, cfg_trig, cfg_extra;

  int n_chk = 0;
  int n_err = 0;
  logic       last_push;
  logic       last_pop;
  logic [7:0] rv;

  always #4 clk = ~clk;

  uart_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_data(rx_data), .st_line(st_line), .st_modem(st_modem),
    .st_intr(st_intr), .lvl_tx(lvl_tx), .lvl_rx(lvl_rx),
    .thr_push(thr_push), .thr_data(thr_data), .rhr_pop(rhr_pop),
    .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr),
    .core_sw_rst(core_sw_rst), .cfg_int_en(cfg_int_en),
    .cfg_fifo_ctl(cfg_fifo_ctl), .cfg_line(cfg_line), .cfg_modem(cfg_modem),
    .cfg_divisor(cfg_divisor), .cfg_enh(cfg_enh), .cfg_xon_a(cfg_xon_a),
    .cfg_xon_b(cfg_xon_b), .cfg_xoff_a(cfg_xoff_a), .cfg_xoff_b(cfg_xoff_b),
    .cfg_tx_ctl(cfg_tx_ctl), .cfg_trig(cfg_trig), .cfg_extra(cfg_extra)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive on falling edge, sample combinational push, release after rising edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #2 last_push = thr_push;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata; last_pop = rhr_pop;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    check("R8 reset line", {8'h0, cfg_line}, 16'h0);
    check("R8 reset strobes", {11'h0, thr_push, rhr_pop, rx_fifo_clr, tx_fifo_clr, core_sw_rst}, 16'h0);
    rd(4'h3, rv); check("R1 line read", {8'h0, rv}, 16'h0);
  endtask

  task automatic t_general;
    rd(4'h0, rv);
    check("R2 rx data", {8'h0, rv}, 16'h00C3);
    check("R7 pop on read", {15'h0, last_pop}, 16'h1);
    rd(4'h5, rv); check("R2 line status", {8'h0, rv}, 16'h0061);
    rd(4'h6, rv); check("R2 modem status", {8'h0, rv}, 16'h0010);
    rd(4'h2, rv); check("R2 intr status", {8'h0, rv}, 16'h00C1);
    rd(4'h8, rv); check("R2 tx level", {8'h0, rv}, 16'h0040);
    rd(4'h9, rv); check("R2 rx level", {8'h0, rv}, 16'h0005);
    wr(4'h7, 8'h5A); rd(4'h7, rv); check("R2 scratch", {8'h0, rv}, 16'h005A);
    wr(4'h0, 8'h9E);
    check("R7 push on write", {15'h0, last_push}, 16'h1);
    check("R7 push data", {8'h0, thr_data}, 16'h009E);
  endtask

  task automatic t_protect;
    wr(4'h1, 8'hFF); rd(4'h1, rv); check("R4 inten locked", {8'h0, rv}, 16'h000F);
    wr(4'h4, 8'hFF); rd(4'h4, rv); check("R4 modem locked", {8'h0, rv}, 16'h0012);
    wr(4'h2, 8'hF1); check("R4 fifo locked", {8'h0, cfg_fifo_ctl}, 16'h00C1);
    wr(4'h3, 8'hBF); wr(4'h2, 8'h10);
    check("R10 enh write", {8'h0, cfg_enh}, 16'h0010);
    wr(4'h3, 8'h00);
    wr(4'h1, 8'hFF); rd(4'h1, rv); check("R4 inten open", {8'h0, rv}, 16'h00FF);
    wr(4'h4, 8'hE6); rd(4'h4, rv); check("R4 modem open", {8'h0, rv}, 16'h00E6);
  endtask

  task automatic t_overlay;
    wr(4'h6, 8'h33); rd(4'h6, rv); check("R3 txctl read", {8'h0, rv}, 16'h0033);
    check("R3 txctl out", {8'h0, cfg_tx_ctl}, 16'h0033);
    wr(4'h7, 8'h44); rd(4'h7, rv); check("R3 trig read", {8'h0, rv}, 16'h0044);
    wr(4'h4, 8'hE2);
    rd(4'h6, rv); check("R3 overlay off status", {8'h0, rv}, 16'h0010);
    rd(4'h7, rv); check("R3 overlay off scratch", {8'h0, rv}, 16'h005A);
  endtask

  task automatic t_banks;
    wr(4'h3, 8'h80);
    wr(4'h0, 8'h12); check("R7 no push in divisor bank", {15'h0, last_push}, 16'h0);
    wr(4'h1, 8'h34);
    check("R10 divisor", cfg_divisor, 16'h3412);
    rd(4'h0, rv); check("R10 divisor low read", {8'h0, rv}, 16'h0012);
    check("R7 no pop in divisor bank", {15'h0, last_pop}, 16'h0);
    rd(4'h7, rv); check("R9 divisor bank unmapped", {8'h0, rv}, 16'h0);
    rd(4'h3, rv); check("R1 line in divisor bank", {8'h0, rv}, 16'h0080);
    wr(4'h3, 8'hBF);
    wr(4'h4, 8'hA1); wr(4'h5, 8'hA2); wr(4'h6, 8'hA3); wr(4'h7, 8'hA4);
    rd(4'h4, rv); check("R10 xon a", {8'h0, rv}, 16'h00A1);
    rd(4'h5, rv); check("R10 xon b", {8'h0, rv}, 16'h00A2);
    rd(4'h6, rv); check("R10 xoff a", {8'h0, rv}, 16'h00A3);
    rd(4'h7, rv); check("R10 xoff b", {8'h0, rv}, 16'h00A4);
    rd(4'h2, rv); check("R1 enh reg in enh bank", {8'h0, rv}, 16'h0010);
    rd(4'h0, rv); check("R1 addr0 unmapped in enh bank", {8'h0, rv}, 16'h0);
    wr(4'h3, 8'h03);
    rd(4'h4, rv); check("R1 back to general", {8'h0, rv}, 16'h00E2);
    rd(4'h1, rv); check("R1 inten untouched", {8'h0, rv}, 16'h00FF);
  endtask

  task automatic t_fifo_reset;
    wr(4'h2, 8'hF3);
    check("R5 rx clr pulse", {14'h0, rx_fifo_clr, tx_fifo_clr}, 16'h2);
    check("R5 fifo stored", {8'h0, cfg_fifo_ctl}, 16'h00F1);
    rd(4'h0, rv); check("R6 pop blocked 1", {15'h0, last_pop}, 16'h0);
    check("R5 rx clr one cycle", {15'h0, rx_fifo_clr}, 16'h0);
    rd(4'h0, rv); check("R6 pop blocked 2", {15'h0, last_pop}, 16'h0);
    rd(4'h0, rv); check("R6 pop allowed", {15'h0, last_pop}, 16'h1);
    wr(4'h2, 8'hF5);
    check("R5 tx clr pulse", {14'h0, rx_fifo_clr, tx_fifo_clr}, 16'h1);
    wr(4'h0, 8'h11); check("R6 push blocked 1", {15'h0, last_push}, 16'h0);
    wr(4'h0, 8'h22); check("R6 push blocked 2", {15'h0, last_push}, 16'h0);
    wr(4'h0, 8'h33); check("R6 push allowed", {15'h0, last_push}, 16'h1);
  endtask

  task automatic t_unmapped;
    wr(4'hA, 8'h77); rd(4'hA, rv); check("R9 unmapped A", {8'h0, rv}, 16'h0);
    check("R9 write ignored", {8'h0, cfg_line}, 16'h0003);
    rd(4'hD, rv); check("R9 unmapped D", {8'h0, rv}, 16'h0);
    wr(4'hE, 8'h00); rd(4'hE, rv); check("R9 srst reads 0", {8'h0, rv}, 16'h0);
    check("R8 no reset without bit3", {8'h0, cfg_line}, 16'h0003);
    wr(4'h4, 8'hFF); rd(4'h4, rv); check("R9 modem reserved", {8'h0, rv}, 16'h00F6);
    wr(4'hF, 8'hFF); rd(4'hF, rv); check("R9 extra reserved", {8'h0, rv}, 16'h00B7);
  endtask

  task automatic t_swrst;
    wr(4'hE, 8'h08);
    check("R8 sw pulse", {15'h0, core_sw_rst}, 16'h1);
    check("R8 regs cleared", {cfg_line, cfg_int_en}, 16'h0);
    check("R8 enh cleared", {cfg_enh, cfg_modem}, 16'h0);
    check("R8 divisor cleared", cfg_divisor, 16'h0);
    rd(4'h7, rv); check("R8 scratch cleared", {8'h0, rv}, 16'h0);
    check("R8 sw pulse one cycle", {15'h0, core_sw_rst}, 16'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_general();
        t_protect();
        t_overlay();
        t_banks();
        t_fifo_reset();
        t_unmapped();
        t_swrst();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule